// File: doc/BRIEF.md
# Masked Lowest-First Interrupt Encoder

This block merges sixteen level-sensitive interrupt lines into a single request output. A source register takes the level of each input line on every clock. An enable mask, held in a register, selects which sources may raise the request. The request output is high while at least one enabled source is pending. A processor reads the vector location to learn which source to service. That read returns a code for the lowest-numbered pending enabled source, or zero when no such source is pending.

Software reaches the block through a small register port with byte offsets. The vector sits at offset 0 and is read-only. The mask sits at offset 2 and can be read and written. The port accepts byte, halfword and word accesses. A word write is broken into two halfword writes on consecutive cycles, the lower half first. A two-state write sequencer does this split. In state SEQ_IDLE it accepts a request. A word request moves it to SEQ_UPPER, where it applies the upper half and returns to SEQ_IDLE. Byte and halfword requests leave the sequencer in SEQ_IDLE.

Top module: `irq_lowfirst_encoder`

## Requirements
- R1: Bit i of the source register takes the level of `irq_lines[i]` at each rising clock edge, so a line change shows up at the outputs one clock later.
- R2: `irq_out` is high exactly when the source register AND the mask is nonzero. It follows both source changes and mask writes.
- R3: A read of offset 0 returns (i+1)*4, where i is the lowest set bit of source AND mask. It returns 0 when no bit is set. For sixteen lines the largest value is 64.
- R4: Offset 2 holds the 16-bit enable mask. A halfword read returns the mask and a halfword write (`bus_size`=1) replaces it.
- R5: After reset the mask reads 0x0010, the source register is 0 and `irq_out` is low.
- R6: A byte write (`bus_size`=0) takes its data from `bus_wdata[7:0]`. It updates only the byte that `bus_addr[0]` selects, where 0 is bits 7:0 and 1 is bits 15:8, and the other byte keeps its value. A byte read returns the selected byte in `rdata[7:0]`.
- R7: A word write (`bus_size`=2) applies `bus_wdata[15:0]` to the addressed halfword in the request cycle. In the next cycle it applies `bus_wdata[31:16]` to the address plus 2. `bus_busy` is high during that second cycle, and any request presented in that cycle is ignored.
- R8: Reading the vector changes neither the source register nor the mask. Repeated reads return the same value.
- R9: Offsets other than 0 and 2 read as 0, and writes to them are ignored. Writes to offset 0 are ignored.
- R10: A word read (`bus_size`=2) returns the halfword at the address in bits 15:0 and the halfword at the address plus 2 in bits 31:16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | 16 | Level-sensitive interrupt source lines |
| bus_addr | input | 12 | Byte offset of the access |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| bus_wr | input | 1 | Write request strobe |
| bus_wdata | input | 32 | Write data, right-aligned for byte and halfword |
| bus_rdata | output | 32 | Combinational read data for the current address and size |
| bus_busy | output | 1 | High while the upper half of a word write is applied |
| irq_out | output | 1 | Merged interrupt request |

## Verification
The case hardest to reach from the ports is the second cycle of a word write. In that cycle the sequencer is in SEQ_UPPER and a new request must be dropped. The stimulus holds `bus_wr` high through that cycle with a conflicting halfword write to the mask. It then checks that only the latched upper half reached the mask. A vector table covers the lowest-first ordering: several pending sources at once, a source at the top line, and pending sources that are all masked. Byte-lane merges are then checked against a known mask value.

// File: rtl/irqenc_pkg.sv
package irqenc_pkg;
    typedef enum logic [0:0] {
        SEQ_IDLE  = 1'b0,
        SEQ_UPPER = 1'b1
    } seq_state_t;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;
endpackage

// File: rtl/irqenc_lowfirst.sv
// Priority encoder: lowest set bit wins, code is (index + 1) * 4, zero if none.
module irqenc_lowfirst #(
    parameter int N     = 16,
    parameter int VEC_W = $clog2(N + 1) + 2
) (
    input  logic [N-1:0]     pend,
    output logic [VEC_W-1:0] vec_code
);
    always_comb begin
        vec_code = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i]) begin
                vec_code = VEC_W'((i + 1) * 4);
            end
        end
    end
endmodule

// File: rtl/irqenc_wr_seq.sv
// Splits word writes into two halfword writes and maps byte writes onto lanes.
module irqenc_wr_seq
    import irqenc_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [31:0]       req_wdata,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [15:0]       wr_data,
    output logic [1:0]        wr_lanes,
    output logic              busy
);
    seq_state_t        state_q, state_d;
    logic [ADDR_W-1:0] up_addr_q;
    logic [15:0]       up_data_q;
    logic [ADDR_W-1:0] req_half;

    assign req_half = {req_addr[ADDR_W-1:1], 1'b0};

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE:  if (req_wr && req_size == SZ_WORD) state_d = SEQ_UPPER;
            SEQ_UPPER: state_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= SEQ_IDLE;
            up_addr_q <= '0;
            up_data_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == SEQ_IDLE && req_wr && req_size == SZ_WORD) begin
                up_addr_q <= req_half + ADDR_W'(2);
                up_data_q <= req_wdata[31:16];
            end
        end
    end

    always_comb begin
        wr_en    = 1'b0;
        wr_addr  = req_half;
        wr_data  = req_wdata[15:0];
        wr_lanes = 2'b11;
        busy     = 1'b0;
        unique case (state_q)
            SEQ_IDLE: begin
                wr_en = req_wr && (req_size != 2'd3);
                if (req_size == SZ_BYTE) begin
                    wr_data  = {req_wdata[7:0], req_wdata[7:0]};
                    wr_lanes = req_addr[0] ? 2'b10 : 2'b01;
                end
            end
            SEQ_UPPER: begin
                busy    = 1'b1;
                wr_en   = 1'b1;
                wr_addr = up_addr_q;
                wr_data = up_data_q;
            end
        endcase
    end

    AST_UPPER_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == SEQ_UPPER |=> state_q == SEQ_IDLE); // R7
    AST_BUSY_AFTER_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_IDLE && req_wr && req_size == SZ_WORD) |=> busy); // R7
endmodule

// File: rtl/irq_lowfirst_encoder.sv
module irq_lowfirst_encoder
    import irqenc_pkg::*;
#(
    parameter int          NUM_LINES = 16,
    parameter int          ADDR_W    = 12,
    parameter logic [15:0] MASK_RST  = 16'h0010
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_lines,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [1:0]           bus_size,
    input  logic                 bus_wr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic                 bus_busy,
    output logic                 irq_out
);
    localparam int REG_W = 16;
    localparam int LANES = REG_W / 8;
    localparam int VEC_W = $clog2(NUM_LINES + 1) + 2;
    localparam int IDX_W = $clog2(NUM_LINES);
    localparam logic [ADDR_W-1:0] OFF_VEC  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'(2);

    logic [NUM_LINES-1:0] src_q;
    logic [REG_W-1:0]     mask_q;
    logic [NUM_LINES-1:0] pend;
    logic [VEC_W-1:0]     vec_code;
    logic                 wr_en;
    logic [ADDR_W-1:0]    wr_addr;
    logic [15:0]          wr_data;
    logic [1:0]           wr_lanes;
    logic [ADDR_W-1:0]    rd_half;
    logic [15:0]          rd_lo, rd_hi;
    logic                 past_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) src_q <= '0;
        else        src_q <= irq_lines;
    end

    assign pend    = src_q & mask_q[NUM_LINES-1:0];
    assign irq_out = |pend;

    irqenc_lowfirst #(.N(NUM_LINES), .VEC_W(VEC_W)) u_enc (
        .pend     (pend),
        .vec_code (vec_code)
    );

    irqenc_wr_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_wr    (bus_wr),
        .req_addr  (bus_addr),
        .req_size  (bus_size),
        .req_wdata (bus_wdata),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .wr_lanes  (wr_lanes),
        .busy      (bus_busy)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_mask_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mask_q[g*8 +: 8] <= MASK_RST[g*8 +: 8];
            end else if (wr_en && wr_lanes[g] && wr_addr == OFF_MASK) begin
                mask_q[g*8 +: 8] <= wr_data[g*8 +: 8];
            end
        end
    end

    function automatic logic [15:0] read_half(input logic [ADDR_W-1:0] a);
        if (a == OFF_VEC)       return 16'(vec_code);
        else if (a == OFF_MASK) return mask_q;
        else                    return 16'h0000;
    endfunction

    assign rd_half = {bus_addr[ADDR_W-1:1], 1'b0};
    assign rd_lo   = read_half(rd_half);
    assign rd_hi   = read_half(rd_half + ADDR_W'(2));

    always_comb begin
        unique case (bus_size)
            SZ_BYTE: bus_rdata = {24'h0, bus_addr[0] ? rd_lo[15:8] : rd_lo[7:0]};
            SZ_HALF: bus_rdata = {16'h0, rd_lo};
            SZ_WORD: bus_rdata = {rd_hi, rd_lo};
            default: bus_rdata = 32'h0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    logic [VEC_W-3:0] chk_idx;
    assign chk_idx = vec_code[VEC_W-1:2] - 1'b1;

    AST_SRC_TRACKS_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> src_q == $past(irq_lines)); // R1
    AST_IRQ_VS_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == (vec_code != '0)); // R2
    AST_VECTOR_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_code != '0) |-> (chk_idx < NUM_LINES) && pend[chk_idx[IDX_W-1:0]]); // R3
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mask_q)); // R9
endmodule

// File: tb/sim_irq_lowfirst_encoder.sv
`timescale 1ns/1ps
module sim_irq_lowfirst_encoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_lines = '0;
    logic [11:0] bus_addr = '0;
    logic [1:0]  bus_size = 2'd1;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_busy;
    logic        irq_out;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    irq_lowfirst_encoder u0 (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_busy(bus_busy), .irq_out(irq_out)
    );

    typedef struct packed {
        logic [15:0] lines;
        logic [15:0] mask;
        logic [31:0] vec;
        logic        irq;
    } vec_row_t;

    localparam vec_row_t TABLE [8] = '{
        '{16'h0000, 16'hFFFF, 32'd0,  1'b0},
        '{16'h0001, 16'hFFFF, 32'd4,  1'b1},
        '{16'h8000, 16'hFFFF, 32'd64, 1'b1},
        '{16'h8010, 16'hFFFF, 32'd20, 1'b1},
        '{16'h00F0, 16'h00E0, 32'd24, 1'b1},
        '{16'h0F00, 16'h00FF, 32'd0,  1'b0},
        '{16'hFFFF, 16'h0000, 32'd0,  1'b0},
        '{16'h1230, 16'h1200, 32'd40, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [1:0] sz, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_size = sz; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        if (sz == 2'd2) @(negedge clk);
    endtask

    task automatic bus_read(input logic [11:0] a, input logic [1:0] sz, output logic [31:0] d);
        bus_wr = 1'b0; bus_addr = a; bus_size = sz;
        #1;
        d = bus_rdata;
    endtask

    task automatic set_lines(input logic [15:0] v);
        @(negedge clk);
        irq_lines = v;
        @(negedge clk);
    endtask

    initial begin : watchdog
        #200000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R5 reset state
        bus_read(12'h002, 2'd1, rd); check("R5 mask reset", rd, 32'h0010);
        bus_read(12'h000, 2'd1, rd); check("R5 vector reset", rd, 32'h0);
        check("R5 irq reset", {31'h0, irq_out}, 32'h0);

        // R2 R3 R4 table walk
        foreach (TABLE[k]) begin
            bus_write(12'h002, 2'd1, {16'h0, TABLE[k].mask});
            set_lines(TABLE[k].lines);
            bus_read(12'h002, 2'd1, rd); check("R4 mask readback", rd, {16'h0, TABLE[k].mask});
            bus_read(12'h000, 2'd1, rd); check("R3 vector", rd, TABLE[k].vec);
            check("R2 irq", {31'h0, irq_out}, {31'h0, TABLE[k].irq});
        end

        // R1 one clock latency; R2 mask write re-evaluates
        bus_write(12'h002, 2'd1, 32'h0000_0004);
        set_lines(16'h0000);
        @(negedge clk);
        irq_lines = 16'h0004;
        #1 check("R1 before edge", {31'h0, irq_out}, 32'h0);
        @(negedge clk);
        check("R1 after edge", {31'h0, irq_out}, 32'h1);
        bus_write(12'h002, 2'd1, 32'h0000_0000);
        check("R2 mask clear drops irq", {31'h0, irq_out}, 32'h0);

        // R8 repeated vector reads
        bus_write(12'h002, 2'd1, 32'h0000_000C);
        set_lines(16'h000C);
        bus_read(12'h000, 2'd1, rd); check("R8 first read", rd, 32'd12);
        @(negedge clk);
        bus_read(12'h000, 2'd1, rd); check("R8 second read", rd, 32'd12);
        check("R8 irq kept", {31'h0, irq_out}, 32'h1);

        // R6 byte lanes
        bus_write(12'h002, 2'd1, 32'h0000_1234);
        bus_write(12'h003, 2'd0, 32'h0000_00AB);
        bus_read(12'h002, 2'd1, rd); check("R6 high byte", rd, 32'hAB34);
        bus_write(12'h002, 2'd0, 32'h0000_00CD);
        bus_read(12'h002, 2'd1, rd); check("R6 low byte", rd, 32'hABCD);
        bus_read(12'h003, 2'd0, rd); check("R6 byte read", rd, 32'hAB);

        // R7 word write split, request during busy ignored
        @(negedge clk);
        bus_addr = 12'h000; bus_size = 2'd2; bus_wdata = 32'h5A5A_0000; bus_wr = 1'b1;
        @(negedge clk);
        check("R7 busy", {31'h0, bus_busy}, 32'h1);
        bus_addr = 12'h002; bus_size = 2'd1; bus_wdata = 32'h0000_1111;
        @(negedge clk);
        bus_wr = 1'b0;
        check("R7 busy cleared", {31'h0, bus_busy}, 32'h0);
        bus_read(12'h002, 2'd1, rd); check("R7 upper applied", rd, 32'h5A5A);

        // R10 word read: lines 0x000C, mask 0x5A5A -> pending 0x0008 -> vector 16
        bus_read(12'h000, 2'd2, rd); check("R10 word read", rd, 32'h5A5A_0010);

        // R9 undefined offsets and vector writes
        bus_write(12'h004, 2'd1, 32'h0000_9999);
        bus_read(12'h004, 2'd1, rd); check("R9 undefined reads zero", rd, 32'h0);
        bus_read(12'h002, 2'd1, rd); check("R9 mask untouched", rd, 32'h5A5A);
        bus_write(12'h000, 2'd1, 32'h0000_FFFF);
        bus_read(12'h000, 2'd1, rd); check("R9 vector write ignored", rd, 32'd16);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule